// File: doc/BRIEF.md
# Three-Wire Camera Front-End Configuration Register Bank

This block is the control port of a camera analog front-end. A host drives three wires: a serial clock, a data line and a load line. Each frame carries a read/write flag, a 3-bit register address and a data payload, all least significant bit first. While the load line is low, every rising edge of the serial clock captures one bit. The rising edge of the load line then commits a write to the addressed register. On a read frame, the addressed register is driven back on a separate data-out pin instead.

The stored settings drive parallel outputs: operating mode, output mode, clock polarity mode, power-down mode, black clamp level, a 10-bit gain word, two 8-bit DAC codes, and three single-bit enables. The serial wires and the load line are resynchronised into the system clock domain and edge-detected there. A separate standby pin overrides the power-down setting without changing what is stored. The payload length of a write depends on the target register and on the operating mode.

Top module: `cfg_serial_bank`

## Requirements
- R1: A frame starts when the load line falls and clears any partial frame. Bit 0 is the read/write flag (0 = write, 1 = read). Bits 1..3 are the address, least significant bit first. Bits 4 and up are payload bit 0 upward. Each bit is sampled on a serial-clock rising edge while the load line is low.
- R2: A write takes effect only on the rising edge of the load line. No output changes while bits are still being shifted.
- R3: At most 14 serial-clock edges are counted per frame. Further edges, such as the dummy bits of a 16-bit frame, have no effect.
- R4: A write needs 14 edges (10 payload bits). A write frame with fewer edges than its target needs is discarded at load.
- R5: When the operating mode is 01 (aux), a write to the gain word needs only 12 edges. Its 8 payload bits become gain bits 9..2, and gain bits 1..0 become 0.
- R6: Address 0 holds the mode word. Payload bits 1:0 are the operating mode (00 ADC-only, 01 aux, 1x CCD). Bits 3:2 are the output mode, bits 5:4 the clock mode, bits 7:6 the power-down mode (00 normal, 01 high-speed aux, 10 reference standby, 11 shutdown), and bits 9:8 the clamp level.
- R7: Address 4 holds the auxiliary word. Bit 0 is the DAC enable, bit 2 selects the internal gain source, and bit 3 disables even/odd correction. Bit 1 must be 0: a write with bit 1 set is ignored. The word reads back with zeros in all other bits.
- R8: After reset the operating mode is 11 (CCD) and every other field is 0.
- R9: While the standby pin is high, the power-down output reads 10. The stored field is unchanged and reappears when the pin falls.
- R10: Writes to addresses 5..7 are ignored, and reads of those addresses return 0.
- R11: On a read frame, after the 4th edge the data-out pin shows register bit 0. After each further edge it shows the next bit, up to bit 9. A read changes no register.
- R12: Address 1 holds the 10-bit gain word. Addresses 2 and 3 hold the two DAC codes, which take payload bits 7:0 and read back with bits 9:8 as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial clock from host |
| ser_data_in | input | 1 | Serial data from host |
| ser_load | input | 1 | Frame/load line, low during a frame |
| standby_in | input | 1 | Forces reference-standby power state |
| ser_data_out | output | 1 | Readback data, valid during read frames |
| op_mode | output | 2 | Operating mode |
| out_mode | output | 2 | Output data mode |
| clk_mode | output | 2 | Sample/clamp pulse polarity mode |
| pwr_mode | output | 2 | Effective power-down mode |
| clamp_sel | output | 2 | Black clamp level select |
| gain_word | output | 10 | Gain setting |
| dac1_code | output | 8 | First DAC code |
| dac2_code | output | 8 | Second DAC code |
| dac_enable | output | 1 | DAC power enable |
| gain_internal | output | 1 | Gain taken from internal word when 1 |
| eo_corr_off | output | 1 | Even/odd correction disabled when 1 |

## Verification
The bench targets frames that are one edge short: a decoder that commits on any load edge would overwrite the gain with garbage. It sends 16-edge frames whose dummy bits are ones; a counter that did not saturate would corrupt the stored code or wrap the bit index. It writes the gain word with 12 edges in aux mode and checks that the bits land at positions 9..2. It also sets the reserved bit of the auxiliary word, and checks that the output stays put across the shift and toggles standby without losing the stored field. It reads back unmapped addresses, where a decoder that aliased them onto a real register would return non-zero data.

// File: rtl/cfg_pkg.sv
package cfg_pkg;
  localparam int DATA_W     = 10;
  localparam int ADDR_W     = 3;
  localparam int HDR_W      = 1 + ADDR_W;
  localparam int FRAME_W    = HDR_W + DATA_W;
  localparam int CNT_W      = $clog2(FRAME_W + 1);
  localparam int AUX_GAIN_W = 8;
  localparam int DAC_W      = 8;

  typedef enum logic [ADDR_W-1:0] {
    A_MODE = 3'd0,
    A_GAIN = 3'd1,
    A_DAC1 = 3'd2,
    A_DAC2 = 3'd3,
    A_AUX  = 3'd4
  } addr_e;

  typedef struct packed {
    logic [1:0] clamp;
    logic [1:0] pwr;
    logic [1:0] clkm;
    logic [1:0] outm;
    logic [1:0] opm;
  } mode_t;

  localparam logic [1:0] OP_AUX   = 2'b01;
  localparam logic [1:0] PWR_STBY = 2'b10;
  localparam mode_t MODE_RST = '{clamp: 2'b00, pwr: 2'b00, clkm: 2'b00,
                                 outm: 2'b00, opm: 2'b11};
endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] d_out
);
  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else if (s == 0) stage_q[s] <= d_in;
        else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign d_out = stage_q[STAGES-1];
endmodule

// File: rtl/cfg_frame_rx.sv
module cfg_frame_rx
  import cfg_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sck_s,
  input  logic               sdi_s,
  input  logic               sload_s,
  output logic [CNT_W-1:0]   bit_cnt,
  output logic [FRAME_W-1:0] frame_bits,
  output logic               frame_start,
  output logic               frame_end
);
  logic               sck_d, sload_d;
  logic               sck_rise;
  logic [CNT_W-1:0]   cnt_n;
  logic [FRAME_W-1:0] bits_n;

  assign sck_rise    = sck_s & ~sck_d;
  assign frame_start = ~sload_s & sload_d;
  assign frame_end   = sload_s & ~sload_d;

  always_comb begin
    cnt_n  = bit_cnt;
    bits_n = frame_bits;
    if (frame_start) begin
      cnt_n  = '0;
      bits_n = '0;
    end else if (sck_rise && !sload_s && (bit_cnt < CNT_W'(FRAME_W))) begin
      bits_n[bit_cnt] = sdi_s;
      cnt_n           = bit_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_d      <= 1'b0;
      sload_d    <= 1'b1;
      bit_cnt    <= '0;
      frame_bits <= '0;
    end else begin
      sck_d      <= sck_s;
      sload_d    <= sload_s;
      bit_cnt    <= cnt_n;
      frame_bits <= bits_n;
    end
  end

  // R3: edge counter never runs past the frame length
  p_cnt_sat_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= CNT_W'(FRAME_W));

  // R1: a falling load line opens an empty frame
  p_start_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (bit_cnt == '0));
endmodule

// File: rtl/cfg_reg_file.sv
module cfg_reg_file
  import cfg_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_end,
  input  logic [FRAME_W-1:0] frame_bits,
  input  logic [CNT_W-1:0]   bit_cnt,
  output mode_t              mode_q,
  output logic [DATA_W-1:0]  gain_q,
  output logic [DAC_W-1:0]   dac1_q,
  output logic [DAC_W-1:0]   dac2_q,
  output logic               dac_en_q,
  output logic               gsrc_q,
  output logic               eo_off_q,
  output logic               sdout
);
  localparam logic [CNT_W-1:0] NEED_FULL = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] NEED_AUX  = CNT_W'(HDR_W + AUX_GAIN_W);
  localparam int              PAD_W     = DATA_W - DAC_W;

  mode_t               mode_n;
  logic [DATA_W-1:0]   gain_n;
  logic [DAC_W-1:0]    dac1_n, dac2_n;
  logic                dac_en_n, gsrc_n, eo_off_n;
  logic                rnw;
  logic [ADDR_W-1:0]   addr;
  logic [DATA_W-1:0]   payload;
  logic                aux_gain;
  logic [CNT_W-1:0]    need;
  logic                wr_commit;
  logic [DATA_W-1:0]   rd_word;
  logic [CNT_W-1:0]    rd_idx;

  assign rnw      = frame_bits[0];
  assign addr     = frame_bits[HDR_W-1:1];
  assign payload  = frame_bits[FRAME_W-1:HDR_W];
  assign aux_gain = (addr == A_GAIN) && (mode_q.opm == OP_AUX);
  assign need     = aux_gain ? NEED_AUX : NEED_FULL;

  always_comb begin
    mode_n    = mode_q;
    gain_n    = gain_q;
    dac1_n    = dac1_q;
    dac2_n    = dac2_q;
    dac_en_n  = dac_en_q;
    gsrc_n    = gsrc_q;
    eo_off_n  = eo_off_q;
    wr_commit = 1'b0;
    if (frame_end && !rnw && (bit_cnt >= need)) begin
      case (addr)
        A_MODE: begin
          mode_n    = mode_t'(payload);
          wr_commit = 1'b1;
        end
        A_GAIN: begin
          gain_n    = aux_gain ? {payload[AUX_GAIN_W-1:0], {(DATA_W-AUX_GAIN_W){1'b0}}}
                               : payload;
          wr_commit = 1'b1;
        end
        A_DAC1: begin
          dac1_n    = payload[DAC_W-1:0];
          wr_commit = 1'b1;
        end
        A_DAC2: begin
          dac2_n    = payload[DAC_W-1:0];
          wr_commit = 1'b1;
        end
        A_AUX: begin
          if (!payload[1]) begin
            dac_en_n  = payload[0];
            gsrc_n    = payload[2];
            eo_off_n  = payload[3];
            wr_commit = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= MODE_RST;
      gain_q   <= '0;
      dac1_q   <= '0;
      dac2_q   <= '0;
      dac_en_q <= 1'b0;
      gsrc_q   <= 1'b0;
      eo_off_q <= 1'b0;
    end else if (wr_commit) begin
      mode_q   <= mode_n;
      gain_q   <= gain_n;
      dac1_q   <= dac1_n;
      dac2_q   <= dac2_n;
      dac_en_q <= dac_en_n;
      gsrc_q   <= gsrc_n;
      eo_off_q <= eo_off_n;
    end
  end

  always_comb begin
    case (addr)
      A_MODE:  rd_word = DATA_W'(mode_q);
      A_GAIN:  rd_word = gain_q;
      A_DAC1:  rd_word = {{PAD_W{1'b0}}, dac1_q};
      A_DAC2:  rd_word = {{PAD_W{1'b0}}, dac2_q};
      A_AUX:   rd_word = DATA_W'({eo_off_q, gsrc_q, 1'b0, dac_en_q});
      default: rd_word = '0;
    endcase
    rd_idx = bit_cnt - CNT_W'(HDR_W);
    sdout  = 1'b0;
    if (rnw && (bit_cnt >= CNT_W'(HDR_W)) && (bit_cnt < CNT_W'(FRAME_W)))
      sdout = rd_word[rd_idx];
  end

  // R2: stored settings move only on a commit
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_commit |=> ($stable(mode_q) && $stable(gain_q) && $stable(dac1_q) &&
                    $stable(dac2_q) && $stable(dac_en_q) && $stable(gsrc_q) &&
                    $stable(eo_off_q)));

  // R4: no commit from a frame shorter than the shortest legal write
  p_min_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |-> (bit_cnt >= NEED_AUX));

  // R11: read frames never commit
  p_read_no_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && rnw) |-> !wr_commit);
endmodule

// File: rtl/cfg_serial_bank.sv
module cfg_serial_bank
  import cfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ser_clk,
  input  logic        ser_data_in,
  input  logic        ser_load,
  input  logic        standby_in,
  output logic        ser_data_out,
  output logic [1:0]  op_mode,
  output logic [1:0]  out_mode,
  output logic [1:0]  clk_mode,
  output logic [1:0]  pwr_mode,
  output logic [1:0]  clamp_sel,
  output logic [9:0]  gain_word,
  output logic [7:0]  dac1_code,
  output logic [7:0]  dac2_code,
  output logic        dac_enable,
  output logic        gain_internal,
  output logic        eo_corr_off
);
  logic [2:0]         sync_out;
  logic               sck_s, sdi_s, sload_s;
  logic [CNT_W-1:0]   bit_cnt;
  logic [FRAME_W-1:0] frame_bits;
  logic               frame_start, frame_end;
  mode_t              mode_q;
  logic [DATA_W-1:0]  gain_q;
  logic [DAC_W-1:0]   dac1_q, dac2_q;

  cfg_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_in  ({ser_load, ser_data_in, ser_clk}),
    .d_out (sync_out)
  );
  assign sck_s   = sync_out[0];
  assign sdi_s   = sync_out[1];
  assign sload_s = sync_out[2];

  cfg_frame_rx u_rx (
    .clk         (clk),
    .rst_n       (rst_n),
    .sck_s       (sck_s),
    .sdi_s       (sdi_s),
    .sload_s     (sload_s),
    .bit_cnt     (bit_cnt),
    .frame_bits  (frame_bits),
    .frame_start (frame_start),
    .frame_end   (frame_end)
  );

  cfg_reg_file u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_end  (frame_end),
    .frame_bits (frame_bits),
    .bit_cnt    (bit_cnt),
    .mode_q     (mode_q),
    .gain_q     (gain_q),
    .dac1_q     (dac1_q),
    .dac2_q     (dac2_q),
    .dac_en_q   (dac_enable),
    .gsrc_q     (gain_internal),
    .eo_off_q   (eo_corr_off),
    .sdout      (ser_data_out)
  );

  assign op_mode   = mode_q.opm;
  assign out_mode  = mode_q.outm;
  assign clk_mode  = mode_q.clkm;
  assign clamp_sel = mode_q.clamp;
  assign pwr_mode  = standby_in ? PWR_STBY : mode_q.pwr;
  assign gain_word = gain_q;
  assign dac1_code = dac1_q;
  assign dac2_code = dac2_q;
endmodule

// File: tb/sim_cfg_serial_bank.sv
module sim_cfg_serial_bank;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_data_in = 1'b0, ser_load = 1'b1, standby_in = 1'b0;
  logic ser_data_out;
  logic [1:0] op_mode, out_mode, clk_mode, pwr_mode, clamp_sel;
  logic [9:0] gain_word;
  logic [7:0] dac1_code, dac2_code;
  logic dac_enable, gain_internal, eo_corr_off;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  cfg_serial_bank u0 (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data_in(ser_data_in),
    .ser_load(ser_load), .standby_in(standby_in), .ser_data_out(ser_data_out),
    .op_mode(op_mode), .out_mode(out_mode), .clk_mode(clk_mode),
    .pwr_mode(pwr_mode), .clamp_sel(clamp_sel), .gain_word(gain_word),
    .dac1_code(dac1_code), .dac2_code(dac2_code), .dac_enable(dac_enable),
    .gain_internal(gain_internal), .eo_corr_off(eo_corr_off)
  );

  typedef struct packed {
    logic [2:0]  addr;
    logic [15:0] data;
    logic [4:0]  nbits;
    logic [9:0]  exp;
  } vec_t;

  // Write, then read back the addressed register
  localparam vec_t TBL [9] = '{
    '{3'd1, 16'h02A5, 5'd14, 10'h2A5},   // R12 gain
    '{3'd2, 16'h03C7, 5'd14, 10'h0C7},   // R12 dac1 low byte
    '{3'd3, 16'h015A, 5'd14, 10'h05A},   // R12 dac2
    '{3'd0, 16'h02E6, 5'd14, 10'h2E6},   // R6 mode word
    '{3'd4, 16'h000D, 5'd14, 10'h00D},   // R7 aux word
    '{3'd4, 16'h0002, 5'd14, 10'h00D},   // R7 reserved bit set: ignored
    '{3'd1, 16'h03FF, 5'd13, 10'h2A5},   // R4 one edge short: discarded
    '{3'd5, 16'h03FF, 5'd14, 10'h000},   // R10 unmapped
    '{3'd2, 16'hFC11, 5'd16, 10'h011}    // R3 16-edge frame, dummy ones
  };

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    ser_data_in = b;
    wait_clk(4);
    ser_clk = 1'b1;
    wait_clk(6);
    ser_clk = 1'b0;
    wait_clk(4);
  endtask

  task automatic frame_open();
    ser_load = 1'b0;
    wait_clk(6);
  endtask

  task automatic frame_close();
    ser_load = 1'b1;
    wait_clk(10);
  endtask

  task automatic send_hdr(input logic rnw, input logic [2:0] addr);
    send_bit(rnw);
    for (int i = 0; i < 3; i++) send_bit(addr[i]);
  endtask

  task automatic wr(input logic [2:0] addr, input logic [15:0] data, input int nbits);
    frame_open();
    send_hdr(1'b0, addr);
    for (int i = 0; i < nbits - 4; i++) send_bit(data[i]);
    frame_close();
  endtask

  task automatic rd(input logic [2:0] addr, output logic [9:0] val);
    frame_open();
    send_hdr(1'b1, addr);
    for (int i = 0; i < 10; i++) begin
      val[i] = ser_data_out;
      send_bit(1'b0);
    end
    frame_close();
  endtask

  initial begin : watchdog
    for (int c = 0; c < 150000; c++) begin
      @(posedge clk);
      if (done) disable watchdog;
    end
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [9:0] rv;
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(5);

    // R8 reset values
    check("R8 op_mode", op_mode, 2'b11);
    check("R8 pwr_mode", pwr_mode, 2'b00);
    check("R8 gain", gain_word, 0);
    check("R8 dac1", dac1_code, 0);
    check("R8 flags", {dac_enable, gain_internal, eo_corr_off}, 0);
    rd(3'd0, rv);
    check("R8/R11 mode readback", rv, 10'h003);

    // Vector table: R1, R3, R4, R6, R7, R10, R11, R12
    for (int k = 0; k < 9; k++) begin
      wr(TBL[k].addr, TBL[k].data, int'(TBL[k].nbits));
      rd(TBL[k].addr, rv);
      check($sformatf("R1/R11 vector %0d readback", k), rv, TBL[k].exp);
    end

    // R6 field ports from mode word 0x2E6
    check("R6 op_mode", op_mode, 2'b10);
    check("R6 out_mode", out_mode, 2'b01);
    check("R6 clk_mode", clk_mode, 2'b10);
    check("R6 pwr_mode", pwr_mode, 2'b11);
    check("R6 clamp_sel", clamp_sel, 2'b10);
    // R7 / R12 ports
    check("R7 flags", {eo_corr_off, gain_internal, dac_enable}, 3'b111);
    check("R12 gain port", gain_word, 10'h2A5);
    check("R12 dac1 port", dac1_code, 8'h11);
    check("R12 dac2 port", dac2_code, 8'h5A);
    // R11 reads left everything intact
    check("R11 gain after reads", gain_word, 10'h2A5);

    // R2: no change mid-frame, change after load rises
    frame_open();
    send_hdr(1'b0, 3'd3);
    for (int i = 0; i < 10; i++) send_bit(i[0]);
    wait_clk(10);
    check("R2 dac2 held before load", dac2_code, 8'h5A);
    frame_close();
    check("R2 dac2 after load", dac2_code, 8'hAA);

    // R1: a new falling load discards a partial frame
    frame_open();
    send_hdr(1'b0, 3'd2);
    send_bit(1'b1);
    ser_load = 1'b1;
    wait_clk(4);
    wr(3'd2, 16'h0033, 14);
    check("R1 restart frame", dac1_code, 8'h33);

    // R5: aux mode, 12-edge gain write
    wr(3'd0, 16'h0001, 14);
    check("R5 op aux", op_mode, 2'b01);
    wr(3'd1, 16'h00B5, 12);
    check("R5 aux gain", gain_word, 10'h2D4);
    wr(3'd1, 16'h0001, 11);
    check("R5/R4 aux short", gain_word, 10'h2D4);

    // R9 standby override
    check("R9 pwr before", pwr_mode, 2'b00);
    standby_in = 1'b1;
    wait_clk(2);
    check("R9 pwr forced", pwr_mode, 2'b10);
    standby_in = 1'b0;
    wait_clk(2);
    check("R9 pwr restored", pwr_mode, 2'b00);
    rd(3'd0, rv);
    check("R9 stored field", rv, 10'h001);

    // R10 read of another unmapped address
    rd(3'd7, rv);
    check("R10 read addr7", rv, 10'h000);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule